// File: doc/BRIEF.md
# SDRAM Command Front End with Bank Tracking

This block sits on the device side of a four-bank, 16-bit synchronous DRAM interface. On every rising clock edge it samples the chip select, the three command strobes, the clock enable, the bank select, the 12-bit multiplexed address and one mask bit per byte lane. It turns the strobe pattern into one decoded command pulse and keeps, for each bank, whether a row is open and which row that is. It also reports the bank, row and column of the last accepted command.

Two byte-lane enables leave the block. A read-side enable follows the lane masks through a two-stage pipeline, so a lane can be tri-stated on the output side. A write-side enable follows the masks with no delay, so a write can be blocked on the lane where it is masked. A clock-enable driven suspend freezes the command path and the read pipeline. It starts and ends one edge after the clock enable changes.

A read or write to a closed bank, or an activate to an open bank, sets a sticky error flag. The offending command is otherwise dropped.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset every bank is closed, all strobes, lane enables and address outputs are zero, the block is not suspended and the error flag is clear.
- R2: With chip select low and the block not suspended, the strobe pattern {row, col, write} (active low, sampled at an edge) decodes as follows: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop, 111 no-op. The matching strobe output is high for exactly the one cycle after that edge, and at most one strobe is high at a time.
- R3: With chip select high, the strobe pins are ignored. Neither a deselect nor a no-op produces a strobe or ends a running read or write burst.
- R4: An accepted activate opens the bank named by the bank select. It stores all 12 address bits as that bank's row, which appears in bits [12b+11:12b] of the open-row output, and it also drives the row output.
- R5: An accepted read or write takes its bank from the bank select at that edge and its column from address bits 7:0. Address bits 11:8 are ignored.
- R6: A precharge with address bit 10 high closes every bank. With bit 10 low it closes only the selected bank.
- R7: A read or write to a closed bank, or an activate to an open bank, produces no strobe and changes no bank state. It sets the error flag, which stays set until reset.
- R8: While a read burst runs, a lane mask bit sampled at edge k clears that lane's read enable (high = lane driven) in the cycle after edge k+1. An unmasked lane reads 1 there.
- R9: On a write edge, and on every later edge while the write burst runs, the write enable for a lane equals the inverse of that lane's mask in the same cycle, with no register on the path.
- R10: A read burst ends on an accepted write, burst stop or precharge. A write burst ends on an accepted read, burst stop or precharge.
- R11: If the clock enable is sampled low while at least one bank is open, the command at that edge is still executed, the suspend output rises after that edge, and commands at later edges are ignored.
- R12: The command on the edge where the clock enable is first sampled high again is still ignored. The next edge is accepted. While suspended, the read-enable pipeline holds its value.
- R13: A low clock enable sampled while every bank is closed does not suspend the block, and the command on that edge is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low requests suspend |
| chip_sel_n | input | 1 | Active-low chip select |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| write_n | input | 1 | Active-low write strobe |
| bank_sel | input | 2 | Bank select |
| mux_addr | input | 12 | Multiplexed row/column address |
| lane_mask | input | 2 | Byte-lane masks, high = masked |
| act_stb | output | 1 | Activate accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| pre_stb | output | 1 | Precharge accepted |
| ref_stb | output | 1 | Refresh accepted |
| mrs_stb | output | 1 | Mode set accepted |
| bst_stb | output | 1 | Burst stop accepted |
| cmd_bank | output | 2 | Bank of last bank-addressed command |
| cmd_row | output | 12 | Row of last activate |
| cmd_col | output | 8 | Column of last read or write |
| bank_open | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Per-bank open row, 12 bits per bank |
| rd_oe | output | 2 | Read-side lane output enable |
| wr_be | output | 2 | Write-side lane enable |
| suspended | output | 1 | Suspend active |
| proto_err | output | 1 | Sticky protocol-error flag |

## Verification
The hardest state to reach is the suspend boundary with a read pipeline that is still non-empty. The bench opens a bank with clock enable already low, which must not suspend. It then issues a read on the next low edge, so the entry edge still executes the read and loads the pipeline. Commands and lane masks applied during the suspend must then leave the read enables frozen at a value that differs from the unfrozen one. The first edge after clock enable returns high must be ignored, and the one after that accepted. A cycle-level reference model compares every output in every cycle.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [3:0] {
      OP_DESEL,
      OP_NOP,
      OP_ACT,
      OP_RD,
      OP_WR,
      OP_PRE,
      OP_REF,
      OP_MRS,
      OP_BST
   } op_e;

   function automatic op_e decode_op(input logic sel_n, input logic r_n,
                                     input logic c_n, input logic w_n);
      op_e res;
      if (sel_n) begin
         res = OP_DESEL;
      end else begin
         unique case ({r_n, c_n, w_n})
            3'b011:  res = OP_ACT;
            3'b101:  res = OP_RD;
            3'b100:  res = OP_WR;
            3'b010:  res = OP_PRE;
            3'b001:  res = OP_REF;
            3'b000:  res = OP_MRS;
            3'b110:  res = OP_BST;
            default: res = OP_NOP;
         endcase
      end
      return res;
   endfunction

endpackage

// File: rtl/sdc_susp_ctl.sv
module sdc_susp_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_en,
   input  logic any_open,
   output logic susp
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        susp <= 1'b0;
      else if (clk_en)   susp <= 1'b0;
      else if (any_open) susp <= 1'b1;
   end

   // R11: entry one edge after a low enable with a bank open
   p_susp_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en && any_open) |=> susp);

   // R12: a high enable always clears suspend after that edge
   p_susp_exit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |=> !susp);

endmodule

// File: rtl/sdc_bank_table.sv
module sdc_bank_table #(
   parameter int NUM_BANKS   = 4,
   parameter int ROW_W       = 12,
   parameter int PRE_ALL_BIT = 10,
   localparam int BA_W       = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       act_en,
   input  logic                       pre_en,
   input  logic [BA_W-1:0]            bank,
   input  logic [ROW_W-1:0]           addr,
   output logic [NUM_BANKS-1:0]       is_open,
   output logic [NUM_BANKS*ROW_W-1:0] rows
);

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic             hit;
      logic [ROW_W-1:0] row_q;
      assign hit = (bank == BA_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            is_open[b] <= 1'b0;
            row_q      <= '0;
         end else if (act_en && hit) begin
            is_open[b] <= 1'b1;
            row_q      <= addr;
         end else if (pre_en && (addr[PRE_ALL_BIT] || hit)) begin
            is_open[b] <= 1'b0;
         end
      end
      assign rows[b*ROW_W +: ROW_W] = row_q;
   end

   // R6: a precharge with the all-banks bit closes every bank
   p_pre_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en && addr[PRE_ALL_BIT]) |=> (is_open == '0));

   // R4: an activate leaves its bank open
   p_act_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
      act_en |=> is_open[$past(bank)]);

endmodule

// File: rtl/sdc_rd_lane_pipe.sv
module sdc_rd_lane_pipe #(
   parameter int LANES = 2,
   parameter int LAT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic [LANES-1:0] lane_in,
   output logic [LANES-1:0] lane_out
);

   if (LAT == 0) begin : g_direct
      assign lane_out = lane_in;
   end else begin : g_shift
      logic [LANES-1:0] st [LAT];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < LAT; i++) st[i] <= '0;
         end else if (adv) begin
            st[0] <= lane_in;
            for (int i = 1; i < LAT; i++) st[i] <= st[i-1];
         end
      end
      assign lane_out = st[LAT-1];

      // R12: a frozen pipeline keeps its output
      p_frozen_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
         !adv |=> $stable(lane_out));
   end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front #(
   parameter int NUM_BANKS   = 4,
   parameter int ROW_W       = 12,
   parameter int COL_W       = 8,
   parameter int LANES       = 2,
   parameter int RD_MASK_LAT = 2,
   parameter int PRE_ALL_BIT = 10,
   localparam int BA_W       = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clk_en,
   input  logic                       chip_sel_n,
   input  logic                       row_strobe_n,
   input  logic                       col_strobe_n,
   input  logic                       write_n,
   input  logic [BA_W-1:0]            bank_sel,
   input  logic [ROW_W-1:0]           mux_addr,
   input  logic [LANES-1:0]           lane_mask,
   output logic                       act_stb,
   output logic                       rd_stb,
   output logic                       wr_stb,
   output logic                       pre_stb,
   output logic                       ref_stb,
   output logic                       mrs_stb,
   output logic                       bst_stb,
   output logic [BA_W-1:0]            cmd_bank,
   output logic [ROW_W-1:0]           cmd_row,
   output logic [COL_W-1:0]           cmd_col,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] open_rows,
   output logic [LANES-1:0]           rd_oe,
   output logic [LANES-1:0]           wr_be,
   output logic                       suspended,
   output logic                       proto_err
);
   import sdc_pkg::*;

   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (COL_W > ROW_W) begin : g_bad_col
      $error("COL_W may not exceed ROW_W");
   end
   if (PRE_ALL_BIT >= ROW_W || PRE_ALL_BIT < COL_W) begin : g_bad_pre
      $error("PRE_ALL_BIT must lie above the column field inside the row");
   end

   logic live, sel_open;
   op_e  op;
   logic acc_act, acc_rd, acc_wr, acc_pre, bad_cmd;
   logic rd_run, wr_run, rd_run_nx;
   logic [LANES-1:0] rd_lane;

   assign live     = !suspended;
   assign op       = live ? decode_op(chip_sel_n, row_strobe_n, col_strobe_n, write_n)
                          : OP_DESEL;
   assign sel_open = bank_open[bank_sel];
   assign acc_act  = (op == OP_ACT) && !sel_open;
   assign acc_rd   = (op == OP_RD)  &&  sel_open;
   assign acc_wr   = (op == OP_WR)  &&  sel_open;
   assign acc_pre  = (op == OP_PRE);
   assign bad_cmd  = ((op == OP_ACT) && sel_open) ||
                     (((op == OP_RD) || (op == OP_WR)) && !sel_open);

   sdc_susp_ctl u_susp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_en   (clk_en),
      .any_open (|bank_open),
      .susp     (suspended)
   );

   sdc_bank_table #(
      .NUM_BANKS   (NUM_BANKS),
      .ROW_W       (ROW_W),
      .PRE_ALL_BIT (PRE_ALL_BIT)
   ) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_en  (acc_act),
      .pre_en  (acc_pre),
      .bank    (bank_sel),
      .addr    (mux_addr),
      .is_open (bank_open),
      .rows    (open_rows)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb} <= '0;
         cmd_bank  <= '0;
         cmd_row   <= '0;
         cmd_col   <= '0;
         proto_err <= 1'b0;
      end else begin
         act_stb <= acc_act;
         rd_stb  <= acc_rd;
         wr_stb  <= acc_wr;
         pre_stb <= acc_pre;
         ref_stb <= (op == OP_REF);
         mrs_stb <= (op == OP_MRS);
         bst_stb <= (op == OP_BST);
         if (acc_act || acc_rd || acc_wr || acc_pre) cmd_bank <= bank_sel;
         if (acc_act)                                cmd_row  <= mux_addr;
         if (acc_rd || acc_wr)                       cmd_col  <= mux_addr[COL_W-1:0];
         if (bad_cmd)                                proto_err <= 1'b1;
      end
   end

   // burst tracking
   always_comb begin
      rd_run_nx = rd_run;
      if (acc_rd)                                rd_run_nx = 1'b1;
      else if (acc_wr || acc_pre || op == OP_BST) rd_run_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_run <= 1'b0;
         wr_run <= 1'b0;
      end else begin
         rd_run <= rd_run_nx;
         if (acc_wr)                                     wr_run <= 1'b1;
         else if (acc_rd || acc_pre || op == OP_BST)     wr_run <= 1'b0;
      end
   end

   // write lanes: zero latency
   always_comb begin
      wr_be = '0;
      if (acc_wr || (wr_run && live && !(acc_rd || acc_pre || op == OP_BST)))
         wr_be = ~lane_mask;
   end

   // read lanes: fixed mask latency
   assign rd_lane = rd_run_nx ? ~lane_mask : '0;

   sdc_rd_lane_pipe #(
      .LANES (LANES),
      .LAT   (RD_MASK_LAT)
   ) u_rdpipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (live),
      .lane_in  (rd_lane),
      .lane_out (rd_oe)
   );

   // R2: strobes are mutually exclusive
   p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb}));

   // R11: nothing is accepted on an edge seen while suspended
   p_susp_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      suspended |=> !(act_stb | rd_stb | wr_stb | pre_stb | ref_stb | mrs_stb | bst_stb));

   // R7: the error flag is sticky
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

   // R9: no write lane while suspended
   p_wr_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|wr_be) |-> !suspended);

   // R5: a read strobe refers to an open bank
   p_rd_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |-> bank_open[cmd_bank]);

endmodule

// File: tb/sdram_cmd_front_tb.sv
module sdram_cmd_front_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_en = 1'b1;
   logic        chip_sel_n = 1'b1;
   logic        row_strobe_n = 1'b1;
   logic        col_strobe_n = 1'b1;
   logic        write_n = 1'b1;
   logic [1:0]  bank_sel = '0;
   logic [11:0] mux_addr = '0;
   logic [1:0]  lane_mask = '0;
   logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb;
   logic [1:0]  cmd_bank;
   logic [11:0] cmd_row;
   logic [7:0]  cmd_col;
   logic [3:0]  bank_open;
   logic [47:0] open_rows;
   logic [1:0]  rd_oe, wr_be;
   logic        suspended, proto_err;

   always #4 clk = ~clk;   // 125 MHz

   sdram_cmd_front u_dut (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel_n(chip_sel_n),
      .row_strobe_n(row_strobe_n), .col_strobe_n(col_strobe_n), .write_n(write_n),
      .bank_sel(bank_sel), .mux_addr(mux_addr), .lane_mask(lane_mask),
      .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
      .ref_stb(ref_stb), .mrs_stb(mrs_stb), .bst_stb(bst_stb),
      .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
      .bank_open(bank_open), .open_rows(open_rows), .rd_oe(rd_oe), .wr_be(wr_be),
      .suspended(suspended), .proto_err(proto_err)
   );

   localparam int C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100, C_PRE = 3'b010,
                  C_REF = 3'b001, C_MRS = 3'b000, C_BST = 3'b110, C_NOP = 3'b111;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;

   // reference model state
   bit       m_open [4];
   int       m_row  [4];
   bit       m_susp, m_rdrun, m_wrrun, m_err;
   int       m_p0, m_p1;
   int       e_stb, e_bank, e_row, e_col;

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input string tag, input bit ce, input bit sn, input int code,
                      input int ba, input int ad, input int dq);
      bit live, act, rd, wr, pre, rf, mrs, bst, acc_act, acc_rd, acc_wr, any_open, rnx;
      longint rows;
      int exp_wr, lane;
      @(negedge clk);
      rows = 0;
      for (int b = 0; b < 4; b++) rows |= longint'(m_row[b]) << (12 * b);
      chk(tag, "strobes", {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb, bst_stb}, e_stb);
      chk(tag, "bank/row/col", {cmd_bank, cmd_row, cmd_col},
          (longint'(e_bank) << 20) | (longint'(e_row) << 8) | e_col);
      chk(tag, "open", {m_open[3], m_open[2], m_open[1], m_open[0]}, bank_open);
      chk(tag, "rows", open_rows, rows);
      chk(tag, "rd_oe/susp/err", {rd_oe, suspended, proto_err}, {m_p1[1:0], m_susp, m_err});
      clk_en = ce; chip_sel_n = sn;
      {row_strobe_n, col_strobe_n, write_n} = code[2:0];
      bank_sel = ba[1:0]; mux_addr = ad[11:0]; lane_mask = dq[1:0];
      // model: combinational part
      live = !m_susp;
      act = live && !sn && code == C_ACT;
      rd  = live && !sn && code == C_RD;
      wr  = live && !sn && code == C_WR;
      pre = live && !sn && code == C_PRE;
      rf  = live && !sn && code == C_REF;
      mrs = live && !sn && code == C_MRS;
      bst = live && !sn && code == C_BST;
      acc_act = act && !m_open[ba];
      acc_rd  = rd && m_open[ba];
      acc_wr  = wr && m_open[ba];
      exp_wr = (acc_wr || (m_wrrun && live && !(acc_rd || bst || pre))) ? (~dq & 3) : 0;
      #1;
      chk(tag, "wr_be", wr_be, exp_wr);
      // model: edge update
      any_open = m_open[0] | m_open[1] | m_open[2] | m_open[3];
      e_stb = {acc_act, acc_rd, acc_wr, pre, rf, mrs, bst};
      if (acc_act || acc_rd || acc_wr || pre) e_bank = ba;
      if (acc_act) e_row = ad & 'hFFF;
      if (acc_rd || acc_wr) e_col = ad & 'hFF;
      if ((act && m_open[ba]) || ((rd || wr) && !m_open[ba])) m_err = 1;
      if (acc_act) begin m_open[ba] = 1; m_row[ba] = ad & 'hFFF; end
      else if (pre) begin
         for (int b = 0; b < 4; b++) if (ad[10] || b == ba) m_open[b] = 0;
      end
      rnx = m_rdrun;
      if (acc_rd) rnx = 1; else if (acc_wr || pre || bst) rnx = 0;
      m_rdrun = rnx;
      if (acc_wr) m_wrrun = 1; else if (acc_rd || pre || bst) m_wrrun = 0;
      lane = rnx ? (~dq & 3) : 0;
      if (live) begin m_p1 = m_p0; m_p0 = lane; end
      if (ce) m_susp = 0; else if (any_open) m_susp = 1;
   endtask

   initial begin
      for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; end
      m_susp = 0; m_rdrun = 0; m_wrrun = 0; m_err = 0; m_p0 = 0; m_p1 = 0;
      e_stb = 0; e_bank = 0; e_row = 0; e_col = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc("R1",  1, 1, C_NOP, 0, 0,      0);
      cyc("R4",  1, 0, C_ACT, 0, 'hABC,  0);
      cyc("R4",  1, 0, C_ACT, 2, 'h123,  0);
      cyc("R5",  1, 0, C_RD,  0, 'hF5A,  0);
      cyc("R8",  1, 0, C_NOP, 0, 0,      1);
      cyc("R8",  1, 0, C_NOP, 0, 0,      2);
      cyc("R3",  1, 1, C_ACT, 3, 'h777,  0);
      cyc("R8",  1, 0, C_NOP, 0, 0,      3);
      cyc("R9",  1, 0, C_WR,  2, 'h7E5,  1);
      cyc("R9",  1, 0, C_NOP, 0, 0,      2);
      cyc("R3",  1, 1, C_RD,  0, 0,      0);
      cyc("R10", 1, 0, C_BST, 0, 0,      0);
      cyc("R10", 1, 0, C_NOP, 0, 0,      0);
      cyc("R10", 1, 0, C_RD,  2, 'h011,  0);
      cyc("R10", 1, 0, C_PRE, 3, 0,      0);
      cyc("R7",  1, 0, C_RD,  1, 5,      0);
      cyc("R7",  1, 0, C_ACT, 0, 'h555,  0);
      cyc("R2",  1, 0, C_REF, 0, 0,      0);
      cyc("R2",  1, 0, C_MRS, 0, 0,      0);
      cyc("R6",  1, 0, C_PRE, 2, 0,      0);
      cyc("R6",  1, 0, C_ACT, 3, 'hFFF,  0);
      cyc("R6",  1, 0, C_PRE, 0, 'h400,  0);
      cyc("R6",  1, 0, C_NOP, 0, 0,      0);
      cyc("R13", 0, 0, C_ACT, 1, 'h2AA,  0);
      cyc("R11", 0, 0, C_RD,  1, 'h0C3,  0);
      cyc("R11", 0, 0, C_WR,  1, 0,      0);
      cyc("R12", 0, 0, C_NOP, 0, 0,      3);
      cyc("R12", 1, 0, C_BST, 0, 0,      0);
      cyc("R12", 1, 0, C_NOP, 0, 0,      1);
      cyc("R12", 1, 0, C_BST, 0, 0,      0);
      cyc("R12", 1, 0, C_NOP, 0, 0,      0);
      cyc("R1",  1, 1, C_NOP, 0, 0,      0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule